// File: doc/BRIEF.md
# Half-Step Predivider Clock Generator

This block derives a video or audio master clock from a reference clock. The reference has already been chosen, outside this block, from a crystal, a first PLL or a second PLL. The division runs in two stages. A predivider divides by 2, 2.5 or 3. An integer divider then divides by 2 up to 127. The overall period of the output is (predivide code + 3) × divide value half-periods of the reference. The output frequency is therefore twice the reference frequency over that product.

The fractional 2.5 step works on half-cycle resolution. The block counts positions in half-periods of the reference. It registers, on each rising reference edge, the level for the high phase and the level for the low phase of that reference cycle. The output picks one of the two with the reference clock itself. The block also decodes two select bits into a registered source index, which drives an external clock mux. A divide value of 0 or 1 raises an error flag. A new configuration word is taken in only where an output period ends, so a change never cuts a pulse short.

Top module: `halfstep_clkgen`

## Requirements
- R1: The output period equals (predivide code + 3) × divide value half-periods of `src_clk`, repeated without drift.
- R2: Predivide codes 1, 2 and 3 give predivide ratios of 2, 2.5 and 3.
- R3: A predivide code of 0 holds `clk_out` low. After reset the active configuration is all zero, so the output is low.
- R4: Within each period of N half-periods, the output is high for the first ceil(N/2) half-periods and low for the remaining floor(N/2), even when N is odd.
- R5: Field positions in `cfg_word`: divide value in [6:0], predivide code in [9:8], PLL-select in bit 13, external-select in bit 14, enable in bit 15. All other bits are ignored.
- R6: `src_idx` is registered one cycle after `cfg_word`. It is 0 (crystal) when external-select is 0. It is 1 (first PLL) when external-select is 1 and PLL-select is 0. It is 2 (second PLL) when both are 1. It never takes the value 3.
- R7: With the enable bit at 0, `clk_out` stays low.
- R8: A divide value of 0 or 1 holds `clk_out` low. In that case `config_error` is 1 on the cycle after such a word is presented. With a divide value of 2 or more, `config_error` is 0.
- R9: A configuration change made while the output runs takes effect only at the end of the current output period. Every period shows complete high and low phases for one configuration or the other.
- R10: When the output starts from the stopped state, its first half-period is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Already selected reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_word | input | 16 | Divider, predivide code, source-select and enable fields |
| clk_out | output | 1 | Divided master clock |
| src_idx | output | 2 | Decoded source index for the external mux |
| config_error | output | 1 | Divide value below 2 in the presented word |

## Verification
The bench measures the high and low run lengths of `clk_out` in half-periods and compares them with the expected values in a scoreboard. Odd periods, for example 15 or 635 half-periods, expose a design that rounds the 2.5 step to whole cycles. Such a design shows runs of 8/8 or 7/7 in place of 8/7, or drifts from period to period. Two reconfigurations are made mid-run: from an even period to an odd one, and from an odd period to an even one. They catch a design that reloads at once, which shows a runt or a stretched phase in the period where the change lands, or that mishandles the half-cycle carried over a period boundary. Stop cases (code 0, enable 0, divide values 0 and 1) and every select combination are checked, so that a leaking pulse or a swapped decode is reported.

// File: rtl/hsp_pkg.sv
`timescale 1ns/1ps
package hsp_pkg;
  localparam int DIV_W    = 7;
  localparam int CODE_W   = 2;
  localparam int CFG_W    = 16;
  localparam int CODE_LSB = 8;
  localparam int PSEL_BIT = 13;
  localparam int ESEL_BIT = 14;
  localparam int EN_BIT   = 15;
  localparam int HC_W     = DIV_W + 3;   // holds (3+3)*(2^DIV_W-1)
  localparam int SRC_W    = 2;

  typedef struct packed {
    logic              en;
    logic              ext_sel;
    logic              pll_sel;
    logic [CODE_W-1:0] code;
    logic [DIV_W-1:0]  div;
  } hsp_cfg_t;

  typedef enum logic [SRC_W-1:0] {
    SRC_XTAL = 2'd0,
    SRC_PLL1 = 2'd1,
    SRC_PLL2 = 2'd2
  } hsp_src_e;

  function automatic hsp_cfg_t unpack_cfg(input logic [CFG_W-1:0] w);
    hsp_cfg_t c;
    c.en      = w[EN_BIT];
    c.ext_sel = w[ESEL_BIT];
    c.pll_sel = w[PSEL_BIT];
    c.code    = w[CODE_LSB +: CODE_W];
    c.div     = w[DIV_W-1:0];
    return c;
  endfunction

  function automatic logic cfg_runs(input hsp_cfg_t c);
    return c.en && (c.code != '0) && (c.div >= DIV_W'(2));
  endfunction

  // period length in reference half-periods
  function automatic logic [HC_W-1:0] half_len(input hsp_cfg_t c);
    return (HC_W'(c.code) + HC_W'(3)) * HC_W'(c.div);
  endfunction
endpackage

// File: rtl/hsp_cfg_shadow.sv
`timescale 1ns/1ps
module hsp_cfg_shadow
  import hsp_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             load,
  output hsp_cfg_t         act,
  output logic             err_q
);
  hsp_cfg_t incoming;
  assign incoming = unpack_cfg(cfg_word);

  always_ff @(posedge clk) begin
    if (rst) begin
      act   <= '0;
      err_q <= 1'b0;
    end else begin
      if (load) act <= incoming;
      err_q <= (incoming.div < DIV_W'(2));
    end
  end

  AST_ERR_FLAG: assert property (@(posedge clk) disable iff (rst)
    (incoming.div < DIV_W'(2)) |=> err_q); // R8
endmodule

// File: rtl/hsp_src_dec.sv
`timescale 1ns/1ps
module hsp_src_dec
  import hsp_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [CFG_W-1:0] cfg_word,
  output logic [SRC_W-1:0] src_idx
);
  hsp_cfg_t c;
  hsp_src_e sel;
  assign c = unpack_cfg(cfg_word);

  always_comb begin
    if (!c.ext_sel)      sel = SRC_XTAL;
    else if (!c.pll_sel) sel = SRC_PLL1;
    else                 sel = SRC_PLL2;
  end

  always_ff @(posedge clk) begin
    if (rst) src_idx <= SRC_XTAL;
    else     src_idx <= sel;
  end

  AST_SRC_LEGAL: assert property (@(posedge clk) disable iff (rst)
    src_idx != 2'd3); // R6
endmodule

// File: rtl/hsp_phase_gen.sv
`timescale 1ns/1ps
module hsp_phase_gen #(
  parameter int HC_W = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic [HC_W-1:0] n_half,
  input  logic            next_runs,
  output logic            ph_hi,
  output logic            ph_lo,
  output logic            period_end
);
  logic [HC_W-1:0] pos;
  logic [HC_W:0]   n_ext, high_len, nxt, q;
  logic            q_wrap;

  always_comb begin
    n_ext      = {1'b0, n_half};
    high_len   = (n_ext + (HC_W+1)'(1)) >> 1;
    nxt        = {1'b0, pos} + (HC_W+1)'(2);
    q          = {1'b0, pos} + (HC_W+1)'(1);
    q_wrap     = (q >= n_ext);
    period_end = run && (nxt >= n_ext);
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pos   <= '0;
      ph_hi <= 1'b0;
      ph_lo <= 1'b0;
    end else begin
      ph_hi <= ({1'b0, pos} < high_len);
      // second half wrapping into the next period is its first (high) half
      ph_lo <= q_wrap ? next_runs : (q < high_len);
      pos   <= period_end ? HC_W'(nxt - n_ext) : HC_W'(nxt);
    end
  end

  AST_POS_BOUND: assert property (@(posedge clk) disable iff (rst)
    run |-> (pos < n_half)); // R1
  AST_START_HIGH: assert property (@(posedge clk) disable iff (rst)
    (run && pos == '0) |=> ph_hi); // R10
endmodule

// File: rtl/halfstep_clkgen.sv
`timescale 1ns/1ps
module halfstep_clkgen
  import hsp_pkg::*;
(
  input  logic             src_clk,
  input  logic             rst,
  input  logic [CFG_W-1:0] cfg_word,
  output logic             clk_out,
  output logic [SRC_W-1:0] src_idx,
  output logic             config_error
);
  hsp_cfg_t        act;
  logic            run, load, period_end, ph_hi, ph_lo, next_runs;
  logic [HC_W-1:0] n_half;

  assign run       = cfg_runs(act);
  assign n_half    = half_len(act);
  assign next_runs = cfg_runs(unpack_cfg(cfg_word));
  assign load      = !run || period_end;

  hsp_cfg_shadow u_shadow (
    .clk(src_clk), .rst(rst), .cfg_word(cfg_word), .load(load),
    .act(act), .err_q(config_error)
  );

  hsp_phase_gen #(.HC_W(HC_W)) u_phase (
    .clk(src_clk), .rst(rst), .run(run), .n_half(n_half),
    .next_runs(next_runs), .ph_hi(ph_hi), .ph_lo(ph_lo),
    .period_end(period_end)
  );

  hsp_src_dec u_src (
    .clk(src_clk), .rst(rst), .cfg_word(cfg_word), .src_idx(src_idx)
  );

  // high phase of the reference shows ph_hi, low phase shows ph_lo
  assign clk_out = src_clk ? ph_hi : ph_lo;

  AST_LOAD_AT_END: assert property (@(posedge src_clk) disable iff (rst)
    (run && !period_end) |=> $stable(act)); // R9
  AST_STOP_LOW: assert property (@(posedge src_clk) disable iff (rst)
    !run |=> (!ph_hi && !ph_lo)); // R3
endmodule

// File: tb/halfstep_clkgen_tb.sv
`timescale 1ns/1ps
module halfstep_clkgen_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cfg = '0;
  logic        clk_out, config_error;
  logic [1:0]  src_idx;

  int checks = 0, errors = 0;
  bit done = 0;
  bit seen_rise = 0;
  int exp_hi[$], exp_lo[$];
  string exp_tag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  halfstep_clkgen u_dut (
    .src_clk(clk), .rst(rst), .cfg_word(cfg),
    .clk_out(clk_out), .src_idx(src_idx), .config_error(config_error)
  );

  function automatic logic [15:0] mk(bit en, bit esel, bit psel,
                                     logic [1:0] code, logic [6:0] div);
    return {en, esel, psel, 3'b000, code, 1'b0, div};
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(int n, string tag);
    exp_hi.push_back((n + 1) / 2);
    exp_lo.push_back(n / 2);
    exp_tag.push_back(tag);
  endtask

  task automatic wait_empty(string tag);
    for (int i = 0; i < 6000; i++) begin
      @(posedge clk); #1;
      if (exp_hi.size() == 0) return;
    end
    check(0, {tag, " scoreboard drained"}, exp_hi.size(), 0);
    exp_hi.delete(); exp_lo.delete(); exp_tag.delete();
  endtask

  task automatic quiesce();
    @(posedge clk); #1;
    cfg[15] = 1'b0;
    repeat (400) @(posedge clk);
    #1 seen_rise = 0;
  endtask

  task automatic run_case(logic [1:0] code, logic [6:0] div, string tag);
    quiesce();
    cfg = mk(1, 0, 0, code, div);
    for (int i = 0; i < 3; i++) push((code + 3) * div, tag);
    wait_empty(tag);
  endtask

  task automatic low_window(string tag);
    int highs = 0;
    repeat (400) @(posedge clk);
    for (int i = 0; i < 200; i++) begin
      @(posedge clk); #2; if (clk_out) highs++;
      @(negedge clk); #2; if (clk_out) highs++;
    end
    check(highs == 0, tag, highs, 0);
  endtask

  // monitor: run lengths in half-periods, popped against scoreboard
  initial begin
    bit prev = 0;
    int hi = 0, lo = 0;
    @(negedge rst);
    forever begin
      for (int ph = 0; ph < 2; ph++) begin
        if (ph == 0) @(posedge clk); else @(negedge clk);
        #2;
        if (clk_out && !prev) begin
          if (seen_rise && exp_hi.size() > 0) begin
            int eh, el; string t;
            eh = exp_hi.pop_front(); el = exp_lo.pop_front(); t = exp_tag.pop_front();
            check(hi == eh, {t, " high run"}, hi, eh);
            check(lo == el, {t, " low run"}, lo, el);
          end
          seen_rise = 1; hi = 1; lo = 0;
        end else if (clk_out) hi++;
        else lo++;
        prev = clk_out;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      check(0, "watchdog expired", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #2;
    check(clk_out == 1'b0, "R3 reset clk_out", clk_out, 0);
    check(src_idx == 2'd0, "R6 reset src_idx", src_idx, 0);
    check(config_error == 1'b0, "R8 reset config_error", config_error, 0);
    @(posedge clk); #1 rst = 1'b0;

    run_case(2'd1, 7'd2,   "R1 R2 R5 ratio 2 div 2");
    run_case(2'd2, 7'd3,   "R2 R4 ratio 2.5 div 3");
    run_case(2'd3, 7'd5,   "R2 ratio 3 div 5");
    run_case(2'd2, 7'd127, "R4 R5 ratio 2.5 div 127");
    run_case(2'd1, 7'd127, "R1 ratio 2 div 127");

    // R9: reconfigure while running, even -> odd -> even
    quiesce();
    cfg = mk(1, 0, 0, 2'd2, 7'd2);
    push(10, "R9 before change"); push(10, "R9 before change");
    wait_empty("R9 before change");
    cfg = mk(1, 0, 0, 2'd2, 7'd3);
    push(10, "R9 period in progress"); push(15, "R9 after change"); push(15, "R9 after change");
    wait_empty("R9 even to odd");
    cfg = mk(1, 0, 0, 2'd1, 7'd2);
    push(15, "R9 odd period in progress"); push(8, "R9 odd to even"); push(8, "R9 odd to even");
    wait_empty("R9 odd to even");
    check(config_error == 1'b0, "R8 valid divide no error", config_error, 0);

    cfg = mk(1, 0, 0, 2'd0, 7'd5);
    low_window("R3 code 0 holds output low");
    cfg = mk(0, 0, 0, 2'd2, 7'd5);
    low_window("R7 enable 0 holds output low");
    cfg = mk(1, 0, 0, 2'd1, 7'd1);
    low_window("R8 divide 1 holds output low");
    check(config_error == 1'b1, "R8 divide 1 error flag", config_error, 1);
    @(posedge clk); #1 cfg = mk(1, 0, 0, 2'd1, 7'd0);
    @(posedge clk); #2;
    check(config_error == 1'b1, "R8 divide 0 error flag", config_error, 1);
    @(posedge clk); #1 cfg = mk(1, 0, 0, 2'd1, 7'd4);
    @(posedge clk); #2;
    check(config_error == 1'b0, "R8 error clears", config_error, 0);
    quiesce();
    cfg = mk(1, 0, 0, 2'd3, 7'd2);
    push(12, "R10 restart after divide error"); push(12, "R10 restart after divide error");
    wait_empty("R10 restart");

    for (int k = 0; k < 4; k++) begin
      bit e = k[1], p = k[0];
      int exp = !e ? 0 : (!p ? 1 : 2);
      @(posedge clk); #1 cfg = mk(0, e, p, 2'd1, 7'd4);
      @(posedge clk); #2;
      check(src_idx == exp[1:0], "R6 source decode", src_idx, exp);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule